// File: doc/BRIEF.md
# Coalesced Response Splitter

This block sits on the return path of a memory coalescer. A coalescer merges several narrow per-lane requests into one wide request. When it issues that wide request, it hands this block a description of what it merged, and the block stores it in a small table indexed by the tag of the wide request. For every lane and every request slot within a lane, the description holds four things: a valid bit, the original narrow source ID, the 32-bit word offset inside the 128-bit line, and the access size as log2 of the byte count.

When the wide response returns with its tag and 128-bit data line, the block reads the matching table entry and frees it. One cycle later it presents all per-slot responses together. Each response carries the word its slot asked for, trimmed to the slot's size, and is tagged with the slot's original source ID. Several wide requests may be in flight at once, and their responses may return in any order.

Top module: `resp_splitter`

## Requirements
- R1: After reset all table entries are free and every output valid bit is 0; a response whose tag has no recorded entry produces no valid output.
- R2: When rec_valid_i is high at a clock edge, the slot description is stored at the entry selected by rec_tag_i and that entry becomes occupied.
- R3: A response accepted at clock edge N (rsp_valid_i high) is presented on the outputs after edge N, for exactly one cycle, with all slots together; with no response at edge N every output valid bit is 0 after it.
- R4: Each valid output carries the source ID recorded for its own slot, not the wide tag.
- R5: Slot k is lane*2+req and uses bit k of the valid vectors and bits [2k+1:2k] of the source, offset and size vectors; the offset value o selects line bits [32*o+31 : 32*o].
- R6: Size code s keeps the low 2^s bytes of the selected word (0 keeps 8 bits, 1 keeps 16 bits, 2 and 3 keep all 32 bits); the remaining bits are 0.
- R7: Slots with no recorded request give valid 0, and their source and data outputs are 0.
- R8: Two slots in the same lane with the same offset both receive the same word.
- R9: A response frees its entry, so a second response with the same tag produces no valid output.
- R10: Entries with different tags are independent; responses for them may return in any order and back to back.
- R11: When a record and a response name the same tag in one cycle, the response uses the entry stored before that edge and the new record stays stored for a later response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid_i | input | 1 | Store a new entry this cycle |
| rec_tag_i | input | 2 | Wide-request tag selecting the entry |
| rec_slot_valid_i | input | 8 | Per-slot request-present bits |
| rec_src_i | input | 16 | Per-slot original source IDs |
| rec_off_i | input | 16 | Per-slot word offsets |
| rec_size_i | input | 16 | Per-slot log2 byte sizes |
| rsp_valid_i | input | 1 | Wide response arrives this cycle |
| rsp_tag_i | input | 2 | Tag of the wide response |
| rsp_data_i | input | 128 | Wide response data line |
| out_valid_o | output | 8 | Per-slot response valid |
| out_src_o | output | 16 | Per-slot restored source IDs |
| out_data_o | output | 256 | Per-slot 32-bit response data |

## Verification
The hardest case to reach is a record and a response naming the same tag at the same clock edge. At that edge the entry is being freed and refilled at once. The stimulus stores one description under a tag, then in one cycle drives the response for that tag together with a different description for the same tag, then sends a second response. The first response must show the old slots and the second must show the new ones. Responses to tags that were never recorded or were already consumed are driven directly to check that no output turns valid.

// File: rtl/rsp_split_pkg.sv
package rsp_split_pkg;

    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned WORD_W_DFLT = 32;

    // A byte at index b survives a log2 size of lg when b < 2**lg.
    function automatic logic keep_byte(input int unsigned b, input int unsigned lg);
        return ((b >> lg) == 0);
    endfunction

endpackage

// File: rtl/rsp_split_slicer.sv
module rsp_split_slicer #(
    parameter int unsigned LINE_W = 128,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned OFF_W  = 2,
    parameter int unsigned SIZE_W = 2
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [SIZE_W-1:0] lg_size_i,
    output logic [WORD_W-1:0] word_o
);
    import rsp_split_pkg::*;

    localparam int unsigned NWORDS = LINE_W / WORD_W;
    localparam int unsigned NBYTES = WORD_W / BYTE_W;

    logic [WORD_W-1:0] sel_word;

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NWORDS; i++) begin
            if (off_i == OFF_W'(i)) begin
                sel_word = line_i[i*WORD_W +: WORD_W];
            end
        end
    end

    genvar gb;
    generate
        for (gb = 0; gb < NBYTES; gb++) begin : g_byte
            assign word_o[gb*BYTE_W +: BYTE_W] =
                keep_byte(gb, 32'(lg_size_i)) ? sel_word[gb*BYTE_W +: BYTE_W]
                                              : {BYTE_W{1'b0}};
        end
    endgenerate

endmodule

// File: rtl/rsp_split_table.sv
module rsp_split_table #(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned SLOTS   = 8,
    parameter int unsigned SRC_W   = 2,
    parameter int unsigned OFF_W   = 2,
    parameter int unsigned SIZE_W  = 2,
    parameter int unsigned TAG_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [TAG_W-1:0]          wr_tag_i,
    input  logic [SLOTS-1:0]          wr_vld_i,
    input  logic [SLOTS*SRC_W-1:0]    wr_src_i,
    input  logic [SLOTS*OFF_W-1:0]    wr_off_i,
    input  logic [SLOTS*SIZE_W-1:0]   wr_size_i,
    input  logic                      rd_en_i,
    input  logic [TAG_W-1:0]          rd_tag_i,
    output logic                      rd_hit_o,
    output logic [SLOTS-1:0]          rd_vld_o,
    output logic [SLOTS*SRC_W-1:0]    rd_src_o,
    output logic [SLOTS*OFF_W-1:0]    rd_off_o,
    output logic [SLOTS*SIZE_W-1:0]   rd_size_o
);

    typedef struct packed {
        logic [ENTRIES-1:0]                   busy;
        logic [ENTRIES-1:0][SLOTS-1:0]        vld;
        logic [ENTRIES-1:0][SLOTS*SRC_W-1:0]  src;
        logic [ENTRIES-1:0][SLOTS*OFF_W-1:0]  off;
        logic [ENTRIES-1:0][SLOTS*SIZE_W-1:0] size;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    assign rd_hit_o  = tbl_q.busy[rd_tag_i];
    assign rd_vld_o  = tbl_q.vld[rd_tag_i];
    assign rd_src_o  = tbl_q.src[rd_tag_i];
    assign rd_off_o  = tbl_q.off[rd_tag_i];
    assign rd_size_o = tbl_q.size[rd_tag_i];

    always_comb begin
        tbl_d = tbl_q;
        if (rd_en_i) begin
            tbl_d.busy[rd_tag_i] = 1'b0;
        end
        // a record in the same cycle wins over the release
        if (wr_en_i) begin
            tbl_d.busy[wr_tag_i] = 1'b1;
            tbl_d.vld[wr_tag_i]  = wr_vld_i;
            tbl_d.src[wr_tag_i]  = wr_src_i;
            tbl_d.off[wr_tag_i]  = wr_off_i;
            tbl_d.size[wr_tag_i] = wr_size_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // R2
    rec_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> tbl_q.busy[$past(wr_tag_i)]);

    // R9
    rsp_frees_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !(wr_en_i && wr_tag_i == rd_tag_i)) |=> !tbl_q.busy[$past(rd_tag_i)]);

endmodule

// File: rtl/resp_splitter.sv
module resp_splitter #(
    parameter int unsigned NUM_LANES     = 4,
    parameter int unsigned REQS_PER_LANE = 2,
    parameter int unsigned SRC_W         = 2,
    parameter int unsigned SIZE_W        = 2,
    parameter int unsigned LINE_W        = 128,
    parameter int unsigned WORD_W        = rsp_split_pkg::WORD_W_DFLT,
    parameter int unsigned NUM_ENTRIES   = 4
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              rec_valid_i,
    input  logic [$clog2(NUM_ENTRIES)-1:0]                    rec_tag_i,
    input  logic [NUM_LANES*REQS_PER_LANE-1:0]                rec_slot_valid_i,
    input  logic [NUM_LANES*REQS_PER_LANE*SRC_W-1:0]          rec_src_i,
    input  logic [NUM_LANES*REQS_PER_LANE*$clog2(LINE_W/WORD_W)-1:0] rec_off_i,
    input  logic [NUM_LANES*REQS_PER_LANE*SIZE_W-1:0]         rec_size_i,
    input  logic                                              rsp_valid_i,
    input  logic [$clog2(NUM_ENTRIES)-1:0]                    rsp_tag_i,
    input  logic [LINE_W-1:0]                                 rsp_data_i,
    output logic [NUM_LANES*REQS_PER_LANE-1:0]                out_valid_o,
    output logic [NUM_LANES*REQS_PER_LANE*SRC_W-1:0]          out_src_o,
    output logic [NUM_LANES*REQS_PER_LANE*WORD_W-1:0]         out_data_o
);

    localparam int unsigned SLOTS = NUM_LANES * REQS_PER_LANE;
    localparam int unsigned TAG_W = $clog2(NUM_ENTRIES);
    localparam int unsigned OFF_W = $clog2(LINE_W / WORD_W);

    logic                    tbl_hit;
    logic [SLOTS-1:0]        tbl_vld;
    logic [SLOTS*SRC_W-1:0]  tbl_src;
    logic [SLOTS*OFF_W-1:0]  tbl_off;
    logic [SLOTS*SIZE_W-1:0] tbl_size;
    logic [SLOTS*WORD_W-1:0] sliced;

    rsp_split_table #(
        .ENTRIES (NUM_ENTRIES),
        .SLOTS   (SLOTS),
        .SRC_W   (SRC_W),
        .OFF_W   (OFF_W),
        .SIZE_W  (SIZE_W),
        .TAG_W   (TAG_W)
    ) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (rec_valid_i),
        .wr_tag_i  (rec_tag_i),
        .wr_vld_i  (rec_slot_valid_i),
        .wr_src_i  (rec_src_i),
        .wr_off_i  (rec_off_i),
        .wr_size_i (rec_size_i),
        .rd_en_i   (rsp_valid_i),
        .rd_tag_i  (rsp_tag_i),
        .rd_hit_o  (tbl_hit),
        .rd_vld_o  (tbl_vld),
        .rd_src_o  (tbl_src),
        .rd_off_o  (tbl_off),
        .rd_size_o (tbl_size)
    );

    genvar gk;
    generate
        for (gk = 0; gk < SLOTS; gk++) begin : g_slot
            rsp_split_slicer #(
                .LINE_W (LINE_W),
                .WORD_W (WORD_W),
                .OFF_W  (OFF_W),
                .SIZE_W (SIZE_W)
            ) slicer_i (
                .line_i    (rsp_data_i),
                .off_i     (tbl_off[gk*OFF_W +: OFF_W]),
                .lg_size_i (tbl_size[gk*SIZE_W +: SIZE_W]),
                .word_o    (sliced[gk*WORD_W +: WORD_W])
            );
        end
    endgenerate

    typedef struct packed {
        logic [SLOTS-1:0]        valid;
        logic [SLOTS*SRC_W-1:0]  src;
        logic [SLOTS*WORD_W-1:0] data;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = '0;
        if (rsp_valid_i && tbl_hit) begin
            for (int k = 0; k < SLOTS; k++) begin
                if (tbl_vld[k]) begin
                    out_d.valid[k]                  = 1'b1;
                    out_d.src[k*SRC_W +: SRC_W]     = tbl_src[k*SRC_W +: SRC_W];
                    out_d.data[k*WORD_W +: WORD_W]  = sliced[k*WORD_W +: WORD_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid_o = out_q.valid;
    assign out_src_o   = out_q.src;
    assign out_data_o  = out_q.data;

    // R3
    out_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid_o) |-> $past(rsp_valid_i));

    generate
        for (gk = 0; gk < SLOTS; gk++) begin : g_idle_chk
            // R7
            idle_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !out_valid_o[gk] |-> (out_src_o[gk*SRC_W +: SRC_W] == '0 &&
                                      out_data_o[gk*WORD_W +: WORD_W] == '0));
        end
    endgenerate

endmodule

// File: tb/resp_splitter_tb_top.sv
module resp_splitter_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rec_valid_i = 1'b0;
    logic [1:0]   rec_tag_i = '0;
    logic [7:0]   rec_slot_valid_i = '0;
    logic [15:0]  rec_src_i = '0;
    logic [15:0]  rec_off_i = '0;
    logic [15:0]  rec_size_i = '0;
    logic         rsp_valid_i = 1'b0;
    logic [1:0]   rsp_tag_i = '0;
    logic [127:0] rsp_data_i = '0;
    logic [7:0]   out_valid_o;
    logic [15:0]  out_src_o;
    logic [255:0] out_data_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    resp_splitter dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .rec_valid_i      (rec_valid_i),
        .rec_tag_i        (rec_tag_i),
        .rec_slot_valid_i (rec_slot_valid_i),
        .rec_src_i        (rec_src_i),
        .rec_off_i        (rec_off_i),
        .rec_size_i       (rec_size_i),
        .rsp_valid_i      (rsp_valid_i),
        .rsp_tag_i        (rsp_tag_i),
        .rsp_data_i       (rsp_data_i),
        .out_valid_o      (out_valid_o),
        .out_src_o        (out_src_o),
        .out_data_o       (out_data_o)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit mon_on = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int           due;
        logic [7:0]   v;
        logic [15:0]  src;
        logic [255:0] data;
        string        req;
    } exp_t;

    exp_t q[$];

    bit          m_busy [4];
    logic [7:0]  m_v    [4];
    logic [15:0] m_src  [4];
    logic [15:0] m_off  [4];
    logic [15:0] m_size [4];

    task automatic check(string req, string what, logic [255:0] act, logic [255:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rec_set(int tag, logic [7:0] v, logic [15:0] src,
                           logic [15:0] off, logic [15:0] sz);
        rec_valid_i = 1'b1;
        rec_tag_i = 2'(tag);
        rec_slot_valid_i = v;
        rec_src_i = src;
        rec_off_i = off;
        rec_size_i = sz;
        m_busy[tag] = 1'b1;
        m_v[tag] = v;
        m_src[tag] = src;
        m_off[tag] = off;
        m_size[tag] = sz;
    endtask

    task automatic rsp_set(int tag, logic [127:0] line, string req);
        exp_t e;
        e.due = cyc + 1;
        e.v = '0;
        e.src = '0;
        e.data = '0;
        e.req = req;
        if (m_busy[tag]) begin
            for (int k = 0; k < 8; k++) begin
                if (m_v[tag][k]) begin
                    int o;
                    int nb;
                    logic [31:0] w;
                    o = int'(m_off[tag][2*k +: 2]);
                    nb = 1 << m_size[tag][2*k +: 2];
                    w = line[32*o +: 32];
                    if (nb < 4) w = w & ((32'd1 << (8*nb)) - 32'd1);
                    e.v[k] = 1'b1;
                    e.src[2*k +: 2] = m_src[tag][2*k +: 2];
                    e.data[32*k +: 32] = w;
                end
            end
        end
        m_busy[tag] = 1'b0;
        q.push_back(e);
        rsp_valid_i = 1'b1;
        rsp_tag_i = 2'(tag);
        rsp_data_i = line;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        rec_valid_i = 1'b0;
        rsp_valid_i = 1'b0;
    endtask

    // monitor: compare the front expectation when due, otherwise expect silence
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (q.size() > 0 && q[0].due == cyc) begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.req, "valid", 256'(out_valid_o), 256'(e.v));
                    check(e.req, "src",   256'(out_src_o),   256'(e.src));
                    check(e.req, "data",  out_data_o,        e.data);
                end else begin
                    check("R3", "idle valid", 256'(out_valid_o), 256'd0);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    localparam logic [127:0] LINE_A = 128'h01234567_5CA1AB1E_89ABCDEF_DEADBEEF;
    localparam logic [127:0] LINE_B = 128'hF00DCAFE_13572468_A5A5C3C3_7E8D9CAB;

    initial begin
        for (int t = 0; t < 4; t++) m_busy[t] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of outputs
        check("R1", "reset valid", 256'(out_valid_o), 256'd0);
        check("R1", "reset data", out_data_o, 256'd0);
        mon_on = 1;
        tick();

        // R1 R9: nothing recorded, response gives nothing
        rsp_set(0, LINE_A, "R1");
        tick();
        tick();

        // R2 R4 R5 R6 R7 R8: lanes 0 and 2 recorded, lane 0 slots share offset 1
        rec_set(1, 8'b0011_0011,
                {2'd0,2'd0, 2'd0,2'd0, 2'd2,2'd1, 2'd0,2'd0, 2'd2,2'd1},
                {2'd0,2'd0, 2'd0,2'd0, 2'd0,2'd2, 2'd0,2'd0, 2'd1,2'd1},
                {2'd0,2'd0, 2'd0,2'd0, 2'd2,2'd1, 2'd0,2'd0, 2'd2,2'd2});
        tick();
        rsp_set(1, LINE_A, "R4 R5 R6 R8");
        tick();
        tick();

        // R9: second response on a consumed tag
        rsp_set(1, LINE_B, "R9");
        tick();
        tick();

        // R10 R6: three tags, answered out of order and back to back
        rec_set(0, 8'b1000_0001, {2'd3,14'd0} | 16'd2, {2'd3,14'd0} | 16'd3,
                {2'd0,14'd0} | 16'd3);
        tick();
        rec_set(2, 8'b0100_0100, {2'd0,2'd1,6'd0,2'd3,4'd0}, {2'd0,2'd2,6'd0,2'd0,4'd0},
                {2'd0,2'd1,6'd0,2'd0,4'd0});
        tick();
        rec_set(3, 8'hFF, 16'hE4E4, 16'h1B1B, 16'h9C63);
        tick();
        rsp_set(3, LINE_B, "R10");
        tick();
        rsp_set(0, LINE_A, "R10 R6");
        tick();
        rsp_set(2, LINE_B, "R10 R6");
        tick();
        tick();

        // R11: record and response for tag 2 in the same cycle
        rec_set(2, 8'b0000_0011, 16'h0009, 16'h000E, 16'h000A);
        tick();
        rsp_set(2, LINE_A, "R11 old");
        rec_set(2, 8'b1100_0000, 16'h7000, 16'h4000, 16'hA000);
        tick();
        rsp_set(2, LINE_B, "R11 new");
        tick();
        tick();
        tick();

        mon_on = 0;
        check("R3", "queue drained", 256'(q.size()), 256'd0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule